// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a two-wire serial slave that gives a bus master access to a bank of 26 eight-bit control registers at indices 0x00 through 0x19. SCL and SDA are oversampled by the system clock. The block finds START, repeated START and STOP conditions, matches its own 7-bit device address, and acknowledges on the ninth clock pulse. After a match it takes a base register index and then moves data bytes to or from the registers. The register pointer advances after each byte and holds at the last index.

Every register is available in parallel on a flat output bus. A 12-bit divider word is assembled from two registers. The upper register acts only as a staging byte. The combined value reaches the divider output only when the lower register is written, so the value never shows a half-updated state. The only bus output is a pull-low request for an external open-drain SDA driver. The lowest address bit comes from a strap pin, so two of these slaves can share one bus.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset, register 0x00 holds the revision code 0x01, register 0x01 holds 0x69, register 0x02 holds 0xD0, all other registers hold 0x00, divider_o is 1693, and sda_pull_o is 0.
- R2: The device address is binary 100110 followed by addr_strap_i as its LSB. The first byte after a START is sent MSB first and holds the address in bits 7:1 and R/W in bit 0, where 1 means read. On a match, the slave pulls SDA low for the ninth pulse. On a mismatch, it leaves SDA released and changes no register.
- R3: In a write, the byte after the address is the base register index. Each later byte is stored, MSB first, at the current pointer, and the pointer then advances by one. Every data byte is acknowledged.
- R4: During writes the pointer stops at 0x19, so any further bytes overwrite register 0x19.
- R5: A base index above 0x19 gets no acknowledge, and no register changes for the rest of that transfer.
- R6: A read starts at the last base index set and advances after each byte, sending MSB first. An ACK from the master (SDA low) asks for the next byte. A NACK ends the read, and the slave releases SDA.
- R7: A repeated START without a STOP before it is accepted, and address matching starts again.
- R8: Register 0x01 is the staging byte for divider bits 11:4. divider_o changes only when register 0x02 is written, and it then loads {register 0x01, written bits 7:4}. Register 0x02 keeps written bits 7:4 and reads bits 3:0 as zero.
- R9: Register 0x00 is read-only. A write to it is acknowledged and advances the pointer, but the stored value does not change.
- R10: During reads the pointer also stops at 0x19, so further reads return register 0x19 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 10x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| addr_strap_i | input | 1 | Device address LSB |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| regs_o | output | NUM_REGS*8 (208) | All register contents, register i at bits i*8+7:i*8 |
| divider_o | output | 12 | Committed divider value |

## Verification
The assertions assume a master that follows the protocol. SDA changes only while SCL is low, except for START and STOP. The master never signals START or STOP during a cycle in which the slave is pulling SDA low. SCL phases last long enough for the two-flop synchronizer to see every edge. The bench master holds every SCL phase for 20 system clocks and moves SDA 10 clocks into the low phase. It ends a read with a NACK before it issues STOP. A behavioural model in the bench tracks the register array, the pointer and the divider, and it predicts every acknowledge and every read byte.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges with SCL held high on both samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/twi_reg_file.sv
module twi_reg_file #(
  parameter int             NUM_REGS  = 26,
  parameter logic [7:0]     REV       = 8'h01,
  parameter logic [11:0]    DIV_RESET = 12'd1693
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [7:0]            waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [7:0]            raddr_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [11:0]           div_o
);
  localparam int IW = $clog2(NUM_REGS);
  localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

  logic [IW-1:0] ridx;
  logic          div_we;

  assign div_we = we_i && (waddr_i == 8'd2);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_rev
      assign regs_o[7:0] = REV;
    end else begin : g_rw
      localparam logic [7:0] RST = (i == 1) ? DIV_RESET[11:4] :
                                   (i == 2) ? {DIV_RESET[3:0], 4'h0} : 8'h00;
      logic [7:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= RST;
        else if (we_i && waddr_i == 8'(i))
          r_q <= (i == 2) ? {wdata_i[7:4], 4'h0} : wdata_i;
      end
      assign regs_o[i*8 +: 8] = r_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_o <= DIV_RESET;
    else if (div_we) div_o <= {regs_o[15:8], wdata_i[7:4]};
  end

  assign ridx    = raddr_i[IW-1:0];
  assign rdata_o = (raddr_i <= LAST) ? regs_o[32'(ridx)*8 +: 8] : 8'h00;

  a_r8_div_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_we |=> $stable(div_o));
  a_r5_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> waddr_i <= LAST);
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter int         NUM_REGS = 26,
  parameter logic [5:0] DEV_HI   = 6'b100110
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_s_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       strap_i,
  input  logic [7:0] rdata_i,
  output logic [7:0] raddr_o,
  output logic       we_o,
  output logic [7:0] waddr_o,
  output logic [7:0] wdata_o,
  output logic       pull_o
);
  localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

  twi_state_e state_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, ptr_q, ptr_nx;
  logic       rw_q, drv_q, mack_q;
  logic       byte_done, rx_state;

  assign ptr_nx    = (ptr_q == LAST) ? ptr_q : ptr_q + 8'd1;
  assign byte_done = scl_fall_i && (bit_q == 4'd8);
  assign rx_state  = (state_q == ST_DEV) || (state_q == ST_REG) || (state_q == ST_WR);
  assign we_o      = (state_q == ST_WR) && byte_done;
  assign waddr_o   = ptr_q;
  assign wdata_o   = sh_q;
  assign raddr_o   = ptr_q;
  assign pull_o    = drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      drv_q   <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_DEV;
      bit_q   <= '0;
      drv_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      drv_q   <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise_i && bit_q != 4'd8) begin
        sh_q  <= {sh_q[6:0], sda_s_i};
        bit_q <= bit_q + 4'd1;
      end else if (byte_done) begin
        bit_q <= '0;
        unique case (state_q)
          ST_DEV: begin
            if (sh_q[7:1] == {DEV_HI, strap_i}) begin
              rw_q    <= sh_q[0];
              drv_q   <= 1'b1;
              state_q <= ST_DEV_ACK;
            end else state_q <= ST_IDLE;
          end
          ST_REG: begin
            if (sh_q <= LAST) begin
              ptr_q   <= sh_q;
              drv_q   <= 1'b1;
              state_q <= ST_REG_ACK;
            end else state_q <= ST_IDLE;
          end
          default: begin
            ptr_q   <= ptr_nx;
            drv_q   <= 1'b1;
            state_q <= ST_WR_ACK;
          end
        endcase
      end
    end else begin
      unique case (state_q)
        ST_DEV_ACK: if (scl_fall_i) begin
          bit_q <= '0;
          if (rw_q) begin
            sh_q    <= rdata_i;
            drv_q   <= ~rdata_i[7];
            state_q <= ST_RD;
          end else begin
            drv_q   <= 1'b0;
            state_q <= ST_REG;
          end
        end
        ST_REG_ACK, ST_WR_ACK: if (scl_fall_i) begin
          drv_q   <= 1'b0;
          state_q <= ST_WR;
        end
        ST_RD: if (scl_fall_i) begin
          if (bit_q == 4'd7) begin
            drv_q   <= 1'b0;
            ptr_q   <= ptr_nx;
            bit_q   <= '0;
            state_q <= ST_RD_ACK;
          end else begin
            sh_q  <= {sh_q[6:0], 1'b0};
            drv_q <= ~sh_q[6];
            bit_q <= bit_q + 4'd1;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) mack_q <= ~sda_s_i;
          else if (scl_fall_i) begin
            if (mack_q) begin
              sh_q    <= rdata_i;
              drv_q   <= ~rdata_i[7];
              state_q <= ST_RD;
            end else state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  a_r4_ptr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);
  a_r2_release_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pull_o);
  a_r2_pull_stable_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i)) |-> $stable(pull_o));
  a_r6_nack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ACK && scl_fall_i && !mack_q && !start_i && !stop_i)
      |=> (!pull_o && state_q == ST_IDLE));
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter int          NUM_REGS    = 26,
  parameter int          SYNC_STAGES = 2,
  parameter logic [5:0]  DEV_HI      = 6'b100110,
  parameter logic [7:0]  REV         = 8'h01,
  parameter logic [11:0] DIV_RESET   = 12'd1693
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_strap_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [11:0]           divider_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic       we;
  logic [7:0] waddr, wdata, raddr, rdata;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_c),
    .stop_o    (stop_c)
  );

  twi_slave_fsm #(.NUM_REGS(NUM_REGS), .DEV_HI(DEV_HI)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_c),
    .stop_i    (stop_c),
    .strap_i   (addr_strap_i),
    .rdata_i   (rdata),
    .raddr_o   (raddr),
    .we_o      (we),
    .waddr_o   (waddr),
    .wdata_o   (wdata),
    .pull_o    (sda_pull_o)
  );

  twi_reg_file #(.NUM_REGS(NUM_REGS), .REV(REV), .DIV_RESET(DIV_RESET)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .rdata_o(rdata),
    .regs_o (regs_o),
    .div_o  (divider_o)
  );
endmodule

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb_top;
  localparam int NR = 26;
  localparam logic [6:0] OWN = 7'h4D;  // 100110 + strap 1

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic strap = 1'b1;
  logic sda_pull;
  logic [NR*8-1:0] regs;
  logic [11:0] div;
  wire sda_bus = sda_m & ~sda_pull;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0]  m_reg [NR];
  int          m_ptr;
  logic [11:0] m_div;

  always #2 clk = ~clk;

  twi_reg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_strap_i(strap), .sda_pull_o(sda_pull), .regs_o(regs), .divider_o(div)
  );

  task automatic wn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void m_write(logic [7:0] d);
    if (m_ptr == 2) begin
      m_reg[2] = {d[7:4], 4'h0};
      m_div    = {m_reg[1], d[7:4]};
    end else if (m_ptr != 0) m_reg[m_ptr] = d;
    if (m_ptr < NR - 1) m_ptr++;
  endfunction

  task automatic cmp_regs(string tag);
    int bad = -1;
    for (int i = 0; i < NR; i++)
      if (bad < 0 && regs[i*8 +: 8] !== m_reg[i]) bad = i;
    chk(bad < 0, {tag, " regs"}, (bad < 0) ? 0 : int'(regs[bad*8 +: 8]),
        (bad < 0) ? 0 : int'(m_reg[bad]));
    chk(div === m_div, {tag, " divider"}, int'(div), int'(m_div));
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wn(10); sda_m = 0; wn(10); scl_m = 0; wn(10);
  endtask
  task automatic bus_rstart();
    sda_m = 1; wn(10); scl_m = 1; wn(10); sda_m = 0; wn(10); scl_m = 0; wn(10);
  endtask
  task automatic bus_stop();
    sda_m = 0; wn(10); scl_m = 1; wn(10); sda_m = 1; wn(20);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wn(10); scl_m = 1; wn(20); scl_m = 0; wn(10);
    end
    sda_m = 1; wn(10); scl_m = 1; wn(10); ack = !sda_bus; wn(10); scl_m = 0; wn(10);
  endtask

  task automatic recv_byte(bit mack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wn(10); scl_m = 1; wn(10); d[i] = sda_bus; wn(10); scl_m = 0;
    end
    wn(10); sda_m = mack ? 1'b0 : 1'b1; wn(10); scl_m = 1; wn(20); scl_m = 0; wn(10);
    sda_m = 1;
  endtask

  // write transfer: device address, base index, n data bytes
  task automatic wr_txn(logic [6:0] dev, logic [7:0] base, logic [7:0] d [4], int n, string tag);
    bit ack;
    bus_start();
    send_byte({dev, 1'b0}, ack);
    chk(ack == (dev == OWN), {tag, " dev ack"}, ack, dev == OWN);
    if (ack) begin
      send_byte(base, ack);
      chk(ack == (base < NR), {tag, " base ack"}, ack, base < NR);
      if (ack) begin
        m_ptr = base;
        for (int k = 0; k < n; k++) begin
          send_byte(d[k], ack);
          chk(ack, {tag, " data ack"}, ack, 1);
          m_write(d[k]);
        end
      end
    end
    bus_stop();
    cmp_regs(tag);
  endtask

  task automatic rd_bytes(int n, string tag);
    bit ack;
    logic [7:0] got;
    send_byte({OWN, 1'b1}, ack);
    chk(ack, {tag, " read dev ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, got);
      chk(got === m_reg[m_ptr], {tag, " read data"}, got, m_reg[m_ptr]);
      if (m_ptr < NR - 1) m_ptr++;
    end
    chk(sda_pull == 1'b0, {tag, " release after nack"}, sda_pull, 0);
    bus_stop();
  endtask

  task automatic rd_txn(logic [7:0] base, int n, bit rs, string tag);
    bit ack;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    send_byte(base, ack);
    chk(ack, {tag, " base ack"}, ack, 1);
    m_ptr = base;
    if (rs) bus_rstart();
    else begin bus_stop(); bus_start(); end
    rd_bytes(n, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    for (int i = 0; i < NR; i++) m_reg[i] = 8'h00;
    m_reg[0] = 8'h01; m_reg[1] = 8'h69; m_reg[2] = 8'hD0;
    m_div = 12'd1693; m_ptr = 0;
    wn(5); rst_n = 1; wn(5);
    // R1 reset state
    cmp_regs("R1");
    chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);

    d = '{8'hA5, 8'h5A, 8'hC3, 8'h3C};
    wr_txn(OWN, 8'h03, d, 4, "R3 burst write");
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    wr_txn(OWN, 8'h18, d, 4, "R4 saturate write");
    d = '{8'hEE, 8'hEE, 8'h00, 8'h00};
    wr_txn(OWN, 8'h1A, d, 2, "R5 base out of range");
    wr_txn(7'h4C, 8'h05, d, 2, "R2 strap mismatch");
    wr_txn(7'h2D, 8'h05, d, 2, "R2 wrong address");
    d = '{8'h12, 8'h00, 8'h00, 8'h00};
    wr_txn(OWN, 8'h01, d, 1, "R8 staging only");
    d = '{8'hF7, 8'h00, 8'h00, 8'h00};
    wr_txn(OWN, 8'h02, d, 1, "R8 commit");
    d = '{8'h99, 8'h34, 8'h56, 8'h00};
    wr_txn(OWN, 8'h00, d, 3, "R9 read-only rev");

    rd_txn(8'h04, 3, 1'b1, "R7 R6 repeated start read");
    rd_txn(8'h18, 3, 1'b1, "R10 read saturate");
    rd_txn(8'h00, 3, 1'b0, "R6 R8 R9 read after stop");
    // R6 read resumes at last set index
    d = '{8'h00, 8'h00, 8'h00, 8'h00};
    wr_txn(OWN, 8'h03, d, 0, "R6 set base");
    m_ptr = 3;
    bus_start();
    rd_bytes(2, "R6 read from stored base");
    cmp_regs("R6 final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule